// File: doc/BRIEF.md
# Four-Phase Fetch/Execute Sequencer

This block runs a two-stage instruction pipeline off a single oscillator clock. It splits every instruction cycle into four oscillator periods, called phases Q1 to Q4. It owns the program counter, the program-memory address, the prefetch latch and the instruction register. While one instruction executes, the next word is fetched, so straight-line code completes one instruction per cycle.

Data-memory read and write strobes are issued at fixed phases of the execute cycle. An external decoder looks at the instruction register and may raise a branch request with a target address. When it does, the sequencer loads the target into the program counter and discards the word it had already prefetched. That discarded word then runs as a forced no-operation, so a taken branch costs two cycles.

Top module: `quad_fetch_seq`

## Requirements
- R1: `phase` is one-hot, with bit 0 for Q1, bit 1 for Q2, bit 2 for Q3 and bit 3 for Q4. It advances one bit per oscillator clock in the order Q1, Q2, Q3, Q4, then back to Q1. Reset places it at Q1.
- R2: `clk_div4` is high during Q1 and Q2 and low during Q3 and Q4.
- R3: Reset, at any point, sets `pmem_addr` to 0 and `exec_nop` to 1. The first instruction cycle after reset executes a no-operation.
- R4: From the second cycle after reset, `pmem_addr` steps by 2 at the end of Q1 of each cycle. It holds its value through Q2, Q3 and Q4.
- R5: The word on `pmem_rdata` is captured at the end of Q4. It appears on `ir` at the end of Q1 of the following cycle and holds through Q2 to Q4.
- R6: `dmem_rd` is high exactly during Q2 of every cycle whose `exec_nop` is 0.
- R7: `dmem_wr` is high exactly during Q4 of every cycle whose `exec_nop` is 0. It is never high in a flushed cycle.
- R8: `br_req` is sampled at the end of Q1 while `ir` holds a non-flushed instruction. If it is high, `pmem_addr` takes `br_target` in place of the increment. The following cycle runs with `exec_nop` = 1. The instruction at the target executes in the cycle after that.
- R9: `br_req` seen at the end of Q1 while `exec_nop` is 1 is ignored, and the program counter increments normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pmem_addr | output | AW | Program-memory byte address (program counter) |
| pmem_rdata | input | IW | Instruction word read at `pmem_addr` |
| br_req | input | 1 | Branch request from the instruction decoder |
| br_target | input | AW | Branch destination address |
| ir | output | IW | Instruction register |
| exec_nop | output | 1 | Current execute cycle is a forced no-operation |
| phase | output | 4 | One-hot phase, bit 0 = Q1 |
| clk_div4 | output | 1 | Oscillator divided by four |
| dmem_rd | output | 1 | Data-memory operand read strobe |
| dmem_wr | output | 1 | Data-memory destination write strobe |

## Verification
The hardest state to reach is a branch request arriving while the sequencer is executing a flushed word. It arises only when the word just behind a taken branch is itself a branch. The bench's program memory places two branch words at consecutive addresses, 0x10 and 0x12, and decodes branches from `ir` directly. As a result, the flushed copy of the second branch raises `br_req` during the forced no-operation, and the bench confirms the counter keeps stepping from the first target.

// File: rtl/qseq_pkg.sv
package qseq_pkg;
    localparam int NUM_PHASES = 4;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } qphase_e;
endpackage

// File: rtl/qseq_phase_gen.sv
module qseq_phase_gen
    import qseq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    output logic [NUM_PHASES-1:0] phase_oh,
    output logic                  clk_div4
);
    typedef struct packed {
        qphase_e ph;
    } ph_state_t;

    ph_state_t state_d, state_q;

    always_comb begin
        state_d    = state_q;
        state_d.ph = qphase_e'(state_q.ph + 2'd1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '{ph: PH_Q1};
        else        state_q <= state_d;
    end

    for (genvar g = 0; g < NUM_PHASES; g++) begin : g_dec
        assign phase_oh[g] = (state_q.ph == 2'(g));
    end

    assign clk_div4 = ~state_q.ph[1];

    // R1
    phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase_oh) == 1);

    // R1
    phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_oh[NUM_PHASES-1] |=> phase_oh[0]);

    // R2
    div_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_oh[2] |-> !clk_div4);
endmodule

// File: rtl/qseq_pc_unit.sv
module qseq_pc_unit #(
    parameter int             AW        = 16,
    parameter int             STEP      = 2,
    parameter logic [AW-1:0]  RESET_VEC = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          started,
    input  logic          take_br,
    input  logic [AW-1:0] br_target,
    output logic [AW-1:0] pc
);
    typedef struct packed {
        logic [AW-1:0] pc;
    } pc_state_t;

    pc_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (adv) begin
            if (take_br)      state_d.pc = br_target;
            else if (started) state_d.pc = state_q.pc + AW'(STEP);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '{pc: RESET_VEC};
        else        state_q <= state_d;
    end

    assign pc = state_q.pc;

    // R4
    pc_move_q1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pc) |-> $past(adv));
endmodule

// File: rtl/qseq_pipe.sv
module qseq_pipe #(
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          at_q1,
    input  logic          at_q4,
    input  logic [IW-1:0] fetch_word,
    input  logic          flush,
    output logic          pf_valid,
    output logic [IW-1:0] ir,
    output logic          exec_nop
);
    typedef struct packed {
        logic [IW-1:0] pf;
        logic          pf_valid;
        logic [IW-1:0] ir;
        logic          nop;
    } pipe_state_t;

    pipe_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (at_q4) begin
            state_d.pf       = fetch_word;
            state_d.pf_valid = 1'b1;
        end
        if (at_q1) begin
            state_d.ir  = state_q.pf;
            state_d.nop = !state_q.pf_valid || flush;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '{pf: '0, pf_valid: 1'b0, ir: '0, nop: 1'b1};
        else        state_q <= state_d;
    end

    assign pf_valid = state_q.pf_valid;
    assign ir       = state_q.ir;
    assign exec_nop = state_q.nop;

    // R5
    ir_move_q1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ir) |-> $past(at_q1));

    // R8
    flush_gives_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (at_q1 && flush) |=> exec_nop);
endmodule

// File: rtl/quad_fetch_seq.sv
module quad_fetch_seq #(
    parameter int            AW        = 16,
    parameter int            IW        = 16,
    parameter logic [AW-1:0] RESET_VEC = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] pmem_addr,
    input  logic [IW-1:0] pmem_rdata,
    input  logic          br_req,
    input  logic [AW-1:0] br_target,
    output logic [IW-1:0] ir,
    output logic          exec_nop,
    output logic [3:0]    phase,
    output logic          clk_div4,
    output logic          dmem_rd,
    output logic          dmem_wr
);
    import qseq_pkg::*;

    localparam int PC_STEP = IW / 8;

    logic [NUM_PHASES-1:0] phase_oh;
    logic                  pf_valid;
    logic                  take_br;

    qseq_phase_gen u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_oh (phase_oh),
        .clk_div4 (clk_div4)
    );

    assign take_br = phase_oh[0] && br_req && !exec_nop;

    qseq_pc_unit #(.AW(AW), .STEP(PC_STEP), .RESET_VEC(RESET_VEC)) u_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (phase_oh[0]),
        .started   (pf_valid),
        .take_br   (take_br),
        .br_target (br_target),
        .pc        (pmem_addr)
    );

    qseq_pipe #(.IW(IW)) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .at_q1      (phase_oh[0]),
        .at_q4      (phase_oh[3]),
        .fetch_word (pmem_rdata),
        .flush      (take_br),
        .pf_valid   (pf_valid),
        .ir         (ir),
        .exec_nop   (exec_nop)
    );

    assign phase   = phase_oh;
    assign dmem_rd = phase_oh[1] && !exec_nop;
    assign dmem_wr = phase_oh[3] && !exec_nop;

    // R6
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_rd |=> !dmem_rd);

    // R7
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_wr |-> $past(dmem_rd, 2));

    // R8
    branch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_br |=> (pmem_addr == $past(br_target)) && exec_nop);

    // R9
    nop_no_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase[0] && exec_nop) |=> (pmem_addr == $past(pmem_addr)) ||
                                   (pmem_addr == $past(pmem_addr) + AW'(PC_STEP)));
endmodule

// File: tb/quad_fetch_seq_tb.sv
module quad_fetch_seq_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pmem_addr;
    logic [15:0] pmem_rdata;
    logic        br_req;
    logic [15:0] br_target;
    logic [15:0] ir;
    logic        exec_nop;
    logic [3:0]  phase;
    logic        clk_div4;
    logic        dmem_rd;
    logic        dmem_wr;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_fetch_seq dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pmem_addr  (pmem_addr),
        .pmem_rdata (pmem_rdata),
        .br_req     (br_req),
        .br_target  (br_target),
        .ir         (ir),
        .exec_nop   (exec_nop),
        .phase      (phase),
        .clk_div4   (clk_div4),
        .dmem_rd    (dmem_rd),
        .dmem_wr    (dmem_wr)
    );

    // Program image: branch words at 0x10 (to 0x40) and 0x12 (to 0x80), else word = address
    function automatic logic [15:0] word_at(input logic [15:0] a);
        if (a == 16'h0010) return 16'hB020;
        if (a == 16'h0012) return 16'hB040;
        return a;
    endfunction

    assign pmem_rdata = word_at(pmem_addr);
    assign br_req     = (ir[15:12] == 4'hB);
    assign br_target  = {3'b000, ir[11:0], 1'b0};

    function automatic logic [15:0] pc_exp(input int k);
        if (k <= 9) return 16'(2 * k);
        return 16'(16'h0040 + 2 * (k - 10));
    endfunction

    function automatic logic [15:0] ir_exp(input int k);
        if (k <= 10) return word_at(16'(2 * (k - 1)));
        return 16'(16'h0040 + 2 * (k - 11));
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Walk one instruction cycle, sampling every phase at the falling edge
    task automatic run_cycle(output logic [15:0] pc_s, output logic [15:0] ir_s, output logic nop_s);
        nop_s = 1'b1;
        pc_s  = '0;
        ir_s  = '0;
        for (int p = 0; p < 4; p++) begin
            chk(phase == 4'(1 << p), "R1", 32'(phase), 32'(1 << p));
            chk(clk_div4 == (p < 2), "R2", 32'(clk_div4), 32'(p < 2));
            if (p == 1) nop_s = exec_nop;
            if (p == 2) begin
                pc_s = pmem_addr;
                ir_s = ir;
            end
            if (p >= 1) begin
                chk(dmem_rd == (p == 1 && !nop_s), "R6", 32'(dmem_rd), 32'(p == 1 && !nop_s));
                chk(dmem_wr == (p == 3 && !nop_s), "R7", 32'(dmem_wr), 32'(p == 3 && !nop_s));
            end
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk(phase == 4'b0001, "R1", 32'(phase), 32'h1);
        chk(clk_div4 == 1'b1, "R2", 32'(clk_div4), 32'h1);
        chk(pmem_addr == 16'h0, "R3", 32'(pmem_addr), 32'h0);
        chk(exec_nop == 1'b1, "R3", 32'(exec_nop), 32'h1);
        chk(!dmem_rd && !dmem_wr, "R7", 32'({dmem_rd, dmem_wr}), 32'h0);
    endtask

    task automatic t_stream();
        logic [15:0] pc_s, ir_s;
        logic        nop_s;
        do_reset();
        for (int k = 0; k < 14; k++) begin
            run_cycle(pc_s, ir_s, nop_s);
            if (k == 0) begin
                chk(pc_s == 16'h0, "R3", 32'(pc_s), 32'h0);
                chk(nop_s == 1'b1, "R3", 32'(nop_s), 32'h1);
            end else if (k >= 9 && k <= 12) begin
                // R8 branch at 0x10 to 0x40; R9 flushed branch at 0x12 ignored in cycle 10
                chk(pc_s == pc_exp(k), (k == 11) ? "R9" : "R8", 32'(pc_s), 32'(pc_exp(k)));
                chk(nop_s == (k == 10), "R8", 32'(nop_s), 32'(k == 10));
                if (k != 10) chk(ir_s == ir_exp(k), "R8", 32'(ir_s), 32'(ir_exp(k)));
            end else begin
                chk(pc_s == pc_exp(k), "R4", 32'(pc_s), 32'(pc_exp(k)));
                chk(ir_s == ir_exp(k), "R5", 32'(ir_s), 32'(ir_exp(k)));
                chk(nop_s == 1'b0, "R5", 32'(nop_s), 32'h0);
            end
        end
    endtask

    task automatic t_midreset();
        logic [15:0] pc_s, ir_s;
        logic        nop_s;
        do_reset();
        repeat (3) run_cycle(pc_s, ir_s, nop_s);
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(phase == 4'b0001, "R3", 32'(phase), 32'h1);
        chk(pmem_addr == 16'h0, "R3", 32'(pmem_addr), 32'h0);
        chk(exec_nop == 1'b1, "R3", 32'(exec_nop), 32'h1);
        rst_n = 1'b1;
        run_cycle(pc_s, ir_s, nop_s);
        chk(pc_s == 16'h0 && nop_s, "R3", 32'({pc_s, nop_s}), 32'h1);
        run_cycle(pc_s, ir_s, nop_s);
        chk(pc_s == 16'h2, "R4", 32'(pc_s), 32'h2);
        chk(ir_s == 16'h0 && !nop_s, "R5", 32'({ir_s, nop_s}), 32'h0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_stream();
        t_midreset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule